// File: doc/BRIEF.md
# Physical Address Router with Peripheral Bus Remap

This block sits between a load/store source and two downstream targets: a RAM port and a peripheral port. Each request carries a 32-bit physical address. The block decodes that address against a RAM region that starts at zero and a 16 MiB device window. It then forwards the request to the matching port, or answers by itself with a decode error when no region matches.

Requests that go to the peripheral port leave with their address rewritten into the peripheral bus view. The top byte changes and the low 24 bits are kept. Every device access also carries a cache-disable attribute. A separate combinational path performs the reverse mapping, from a bus address back to a physical address, so that software or a descriptor builder can turn bus addresses into physical ones.

Every port uses a valid/ready handshake. Only one request is in flight at a time, and its response is taken from the port that was chosen for it.

Top module: `mmio_router`

## Requirements
- R1: A request whose physical address is below `RAM_BYTES` (default 0x2000_0000) is issued on the RAM port with the address, the write flag and the write data unchanged.
- R2: A request whose address top byte is 0x20 (0x2000_0000 to 0x20FF_FFFF) is issued on the peripheral port with top byte 0x7E and the low 24 bits unchanged.
- R3: While the peripheral port presents a request, `dev_uncached` is 1. While the RAM port presents a request, `dev_uncached` is 0.
- R4: A request to any other address goes to neither port. It gets a response with `rsp_err`=1 and `rsp_rdata`=0.
- R5: `req_ready` is 1 only while no request is in flight. It drops in the cycle after a request is accepted and returns in the cycle after the response is accepted.
- R6: For a routed request, the response carries the read data that the selected port returned, with `rsp_err`=0. Only the selected port sees its response ready.
- R7: On the reverse path, a bus address with top byte 0x7E yields `dma_hit`=1 and a physical address with top byte 0x20 and the same low 24 bits. Any other bus address yields `dma_hit`=0 and physical address 0.
- R8: A downstream request, and the response toward the source, hold valid and their payload stable until the receiver is ready.
- R9: After reset, `req_ready` is 1 and no valid output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Source request valid |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | 32 | Physical address |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response valid toward source |
| rsp_ready | input | 1 | Source accepts response |
| rsp_rdata | output | 32 | Load data, 0 on decode error |
| rsp_err | output | 1 | Decode error flag |
| ram_req_valid | output | 1 | RAM request valid |
| ram_req_ready | input | 1 | RAM accepts request |
| ram_addr | output | 32 | RAM physical address |
| ram_write | output | 1 | RAM store flag |
| ram_wdata | output | 32 | RAM store data |
| ram_rsp_valid | input | 1 | RAM response valid |
| ram_rsp_ready | output | 1 | Router accepts RAM response |
| ram_rsp_rdata | input | 32 | RAM load data |
| dev_req_valid | output | 1 | Peripheral request valid |
| dev_req_ready | input | 1 | Peripheral accepts request |
| dev_addr | output | 32 | Peripheral bus address |
| dev_write | output | 1 | Peripheral store flag |
| dev_wdata | output | 32 | Peripheral store data |
| dev_uncached | output | 1 | Cache-disable attribute of a device access |
| dev_rsp_valid | input | 1 | Peripheral response valid |
| dev_rsp_ready | output | 1 | Router accepts peripheral response |
| dev_rsp_rdata | input | 32 | Peripheral load data |
| dma_bus_addr | input | 32 | Bus address to convert back |
| dma_phys_addr | output | 32 | Converted physical address |
| dma_hit | output | 1 | Bus address lies in the peripheral window |

## Verification
The assertions check the per-cycle properties on every cycle:
- the two downstream valids and the source response are never active together;
- device requests always carry the 0x7E window and the cache-disable bit;
- RAM requests stay below the RAM limit;
- error responses carry zero data;
- stalled handshakes hold their payload;
- acceptance closes the request slot.

Other properties only the bench scenarios can show:
- that a given address lands on the right port with the right rewritten address;
- that returned data reaches the source unchanged;
- the region edges (last RAM byte, both ends of the window, first unmapped address);
- the reverse conversion for hits and misses.

// File: rtl/mmio_route_pkg.sv
package mmio_route_pkg;

   typedef enum logic [1:0] {
      TGT_RAM  = 2'd0,
      TGT_DEV  = 2'd1,
      TGT_NONE = 2'd2
   } route_tgt_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2,
      SQ_RESP  = 2'd3
   } seq_state_e;

endpackage

// File: rtl/mmio_region_dec.sv
module mmio_region_dec
   import mmio_route_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned WIN_BITS = 24,
   parameter longint unsigned RAM_BYTES = 64'h2000_0000,
   parameter logic [ADDR_W-WIN_BITS-1:0] PHYS_TAG = 'h20
) (
   input  logic [ADDR_W-1:0] addr,
   output route_tgt_e        tgt
);
   localparam int unsigned RAM_LOG2 = $clog2(RAM_BYTES);
   localparam bit RAM_POW2 = ((RAM_BYTES & (RAM_BYTES - 64'd1)) == 64'd0);
   localparam logic [ADDR_W:0] RAM_LIMIT = RAM_BYTES[ADDR_W:0];

   logic ram_hit;
   logic dev_hit;

   generate
      if (RAM_POW2) begin : g_ram_mask
         // power-of-two size: all bits above the size must be zero
         assign ram_hit = ((addr >> RAM_LOG2) == '0);
      end else begin : g_ram_cmp
         assign ram_hit = ({1'b0, addr} < RAM_LIMIT);
      end
   endgenerate

   assign dev_hit = (addr[ADDR_W-1:WIN_BITS] == PHYS_TAG);

   always_comb begin
      if (dev_hit)      tgt = TGT_DEV;
      else if (ram_hit) tgt = TGT_RAM;
      else              tgt = TGT_NONE;
   end
endmodule

// File: rtl/mmio_xlate.sv
module mmio_xlate #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned WIN_BITS = 24,
   parameter logic [ADDR_W-WIN_BITS-1:0] FROM_TAG = 'h20,
   parameter logic [ADDR_W-WIN_BITS-1:0] TO_TAG = 'h7E,
   parameter bit ZERO_ON_MISS = 1'b0
) (
   input  logic [ADDR_W-1:0] in_addr,
   output logic [ADDR_W-1:0] out_addr,
   output logic              hit
);
   logic [ADDR_W-1:0] swapped;

   assign hit     = (in_addr[ADDR_W-1:WIN_BITS] == FROM_TAG);
   assign swapped = {TO_TAG, in_addr[WIN_BITS-1:0]};

   generate
      if (ZERO_ON_MISS) begin : g_gated
         assign out_addr = hit ? swapped : '0;
      end else begin : g_plain
         assign out_addr = swapped;
      end
   endgenerate
endmodule

// File: rtl/mmio_seq.sv
module mmio_seq
   import mmio_route_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  route_tgt_e        dec_tgt,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic [ADDR_W-1:0] hold_addr,
   output logic              hold_write,
   output logic [DATA_W-1:0] hold_wdata,
   output logic              ram_sel,
   output logic              dev_sel,
   output logic              ram_req_valid,
   input  logic              ram_req_ready,
   input  logic              ram_rsp_valid,
   output logic              ram_rsp_ready,
   input  logic [DATA_W-1:0] ram_rsp_rdata,
   output logic              dev_req_valid,
   input  logic              dev_req_ready,
   input  logic              dev_rsp_valid,
   output logic              dev_rsp_ready,
   input  logic [DATA_W-1:0] dev_rsp_rdata
);
   seq_state_e        st;
   route_tgt_e        tgt;
   logic [DATA_W-1:0] rdata_q;
   logic              err_q;
   logic              sel_req_ready;
   logic              sel_rsp_valid;
   logic [DATA_W-1:0] sel_rsp_rdata;

   assign ram_sel = (tgt == TGT_RAM);
   assign dev_sel = (tgt == TGT_DEV);

   always_comb begin
      sel_req_ready = ram_sel ? ram_req_ready : dev_req_ready;
      sel_rsp_valid = ram_sel ? ram_rsp_valid : dev_rsp_valid;
      sel_rsp_rdata = ram_sel ? ram_rsp_rdata : dev_rsp_rdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= SQ_IDLE;
         tgt        <= TGT_NONE;
         hold_addr  <= '0;
         hold_write <= 1'b0;
         hold_wdata <= '0;
         rdata_q    <= '0;
         err_q      <= 1'b0;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (req_valid) begin
                  hold_addr  <= req_addr;
                  hold_write <= req_write;
                  hold_wdata <= req_wdata;
                  tgt        <= dec_tgt;
                  rdata_q    <= '0;
                  err_q      <= (dec_tgt == TGT_NONE);
                  st         <= (dec_tgt == TGT_NONE) ? SQ_RESP : SQ_ISSUE;
               end
            end
            SQ_ISSUE: begin
               if (sel_req_ready) st <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (sel_rsp_valid) begin
                  rdata_q <= sel_rsp_rdata;
                  st      <= SQ_RESP;
               end
            end
            SQ_RESP: begin
               if (rsp_ready) st <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign req_ready     = (st == SQ_IDLE);
   assign ram_req_valid = (st == SQ_ISSUE) && ram_sel;
   assign dev_req_valid = (st == SQ_ISSUE) && dev_sel;
   assign ram_rsp_ready = (st == SQ_WAIT) && ram_sel;
   assign dev_rsp_ready = (st == SQ_WAIT) && dev_sel;
   assign rsp_valid     = (st == SQ_RESP);
   assign rsp_rdata     = rdata_q;
   assign rsp_err       = err_q;
endmodule

// File: rtl/mmio_router.sv
module mmio_router
   import mmio_route_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WIN_BITS = 24,
   parameter longint unsigned RAM_BYTES = 64'h2000_0000,
   parameter logic [ADDR_W-WIN_BITS-1:0] PHYS_TAG = 'h20,
   parameter logic [ADDR_W-WIN_BITS-1:0] BUS_TAG = 'h7E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              ram_req_valid,
   input  logic              ram_req_ready,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_write,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic              ram_rsp_valid,
   output logic              ram_rsp_ready,
   input  logic [DATA_W-1:0] ram_rsp_rdata,
   output logic              dev_req_valid,
   input  logic              dev_req_ready,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              dev_write,
   output logic [DATA_W-1:0] dev_wdata,
   output logic              dev_uncached,
   input  logic              dev_rsp_valid,
   output logic              dev_rsp_ready,
   input  logic [DATA_W-1:0] dev_rsp_rdata,
   input  logic [ADDR_W-1:0] dma_bus_addr,
   output logic [ADDR_W-1:0] dma_phys_addr,
   output logic              dma_hit
);
   localparam longint unsigned WIN_BASE = longint'(PHYS_TAG) << WIN_BITS;

   generate
      if (WIN_BITS == 0 || WIN_BITS >= ADDR_W) begin : g_bad_win
         $error("mmio_router: WIN_BITS must lie between 1 and ADDR_W-1");
      end
      if (RAM_BYTES == 0 || RAM_BYTES > WIN_BASE) begin : g_bad_ram
         $error("mmio_router: RAM region must be non-empty and end below the device window");
      end
      if (PHYS_TAG == BUS_TAG) begin : g_bad_tag
         $error("mmio_router: physical and bus window tags must differ");
      end
   endgenerate

   route_tgt_e        dec_tgt;
   logic [ADDR_W-1:0] hold_addr;
   logic              hold_write;
   logic [DATA_W-1:0] hold_wdata;
   logic              ram_sel;
   logic              dev_sel;
   logic              dev_win_hit;

   mmio_region_dec #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS),
      .RAM_BYTES(RAM_BYTES), .PHYS_TAG(PHYS_TAG)
   ) i_dec (
      .addr(req_addr),
      .tgt (dec_tgt)
   );

   mmio_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .req_write    (req_write),
      .req_wdata    (req_wdata),
      .dec_tgt      (dec_tgt),
      .rsp_valid    (rsp_valid),
      .rsp_ready    (rsp_ready),
      .rsp_rdata    (rsp_rdata),
      .rsp_err      (rsp_err),
      .hold_addr    (hold_addr),
      .hold_write   (hold_write),
      .hold_wdata   (hold_wdata),
      .ram_sel      (ram_sel),
      .dev_sel      (dev_sel),
      .ram_req_valid(ram_req_valid),
      .ram_req_ready(ram_req_ready),
      .ram_rsp_valid(ram_rsp_valid),
      .ram_rsp_ready(ram_rsp_ready),
      .ram_rsp_rdata(ram_rsp_rdata),
      .dev_req_valid(dev_req_valid),
      .dev_req_ready(dev_req_ready),
      .dev_rsp_valid(dev_rsp_valid),
      .dev_rsp_ready(dev_rsp_ready),
      .dev_rsp_rdata(dev_rsp_rdata)
   );

   // physical -> bus view for the device port
   mmio_xlate #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS),
      .FROM_TAG(PHYS_TAG), .TO_TAG(BUS_TAG), .ZERO_ON_MISS(1'b0)
   ) i_fwd_map (
      .in_addr (hold_addr),
      .out_addr(dev_addr),
      .hit     (dev_win_hit)
   );

   // bus -> physical view for descriptor addresses
   mmio_xlate #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS),
      .FROM_TAG(BUS_TAG), .TO_TAG(PHYS_TAG), .ZERO_ON_MISS(1'b1)
   ) i_rev_map (
      .in_addr (dma_bus_addr),
      .out_addr(dma_phys_addr),
      .hit     (dma_hit)
   );

   assign ram_addr     = hold_addr;
   assign ram_write    = hold_write;
   assign ram_wdata    = hold_wdata;
   assign dev_write    = hold_write;
   assign dev_wdata    = hold_wdata;
   assign dev_uncached = dev_sel && dev_win_hit && !ram_sel;
endmodule

// File: rtl/mmio_router_chk.sv
module mmio_router_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WIN_BITS = 24,
   parameter longint unsigned RAM_BYTES = 64'h2000_0000,
   parameter logic [ADDR_W-WIN_BITS-1:0] PHYS_TAG = 'h20,
   parameter logic [ADDR_W-WIN_BITS-1:0] BUS_TAG = 'h7E
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_err,
   input logic              ram_req_valid,
   input logic              ram_req_ready,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [DATA_W-1:0] ram_wdata,
   input logic              dev_req_valid,
   input logic              dev_req_ready,
   input logic [ADDR_W-1:0] dev_addr,
   input logic [DATA_W-1:0] dev_wdata,
   input logic              dev_uncached,
   input logic [ADDR_W-1:0] dma_bus_addr,
   input logic [ADDR_W-1:0] dma_phys_addr,
   input logic              dma_hit
);
   localparam logic [ADDR_W:0] RAM_LIMIT = RAM_BYTES[ADDR_W:0];

   a_r1_ram_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ram_req_valid |-> ({1'b0, ram_addr} < RAM_LIMIT));

   a_r2_dev_bus_window: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req_valid |-> (dev_addr[ADDR_W-1:WIN_BITS] == BUS_TAG));

   a_r3_dev_uncached: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req_valid |-> dev_uncached);

   a_r3_ram_cached: assert property (@(posedge clk) disable iff (!rst_n)
      ram_req_valid |-> !dev_uncached);

   a_r4_one_active: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_req_valid, dev_req_valid, rsp_valid}));

   a_r4_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

   a_r5_slot_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r5_busy_while_out: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_req_valid || dev_req_valid || rsp_valid) |-> !req_ready);

   a_r7_rev_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      dma_hit |-> (dma_phys_addr[WIN_BITS-1:0] == dma_bus_addr[WIN_BITS-1:0]
                   && dma_phys_addr[ADDR_W-1:WIN_BITS] == PHYS_TAG));

   a_r8_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_req_valid && !ram_req_ready) |=>
         (ram_req_valid && $stable(ram_addr) && $stable(ram_wdata)));

   a_r8_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_req_valid && !dev_req_ready) |=>
         (dev_req_valid && $stable(dev_addr) && $stable(dev_wdata)));

   a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

bind mmio_router mmio_router_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS),
   .RAM_BYTES(RAM_BYTES), .PHYS_TAG(PHYS_TAG), .BUS_TAG(BUS_TAG)
) i_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
   .ram_req_valid(ram_req_valid), .ram_req_ready(ram_req_ready),
   .ram_addr(ram_addr), .ram_wdata(ram_wdata),
   .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
   .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_uncached(dev_uncached),
   .dma_bus_addr(dma_bus_addr), .dma_phys_addr(dma_phys_addr), .dma_hit(dma_hit)
);

// File: tb/test_mmio_router.sv
`timescale 1ns/1ps
module test_mmio_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic        ram_req_valid;
   logic        ram_req_ready = 1'b0;
   logic [31:0] ram_addr;
   logic        ram_write;
   logic [31:0] ram_wdata;
   logic        ram_rsp_valid = 1'b0;
   logic        ram_rsp_ready;
   logic [31:0] ram_rsp_rdata = '0;
   logic        dev_req_valid;
   logic        dev_req_ready = 1'b0;
   logic [31:0] dev_addr;
   logic        dev_write;
   logic [31:0] dev_wdata;
   logic        dev_uncached;
   logic        dev_rsp_valid = 1'b0;
   logic        dev_rsp_ready;
   logic [31:0] dev_rsp_rdata = '0;
   logic [31:0] dma_bus_addr = '0;
   logic [31:0] dma_phys_addr;
   logic        dma_hit;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mmio_router i_mmio_router (.*);

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // 0 = RAM, 1 = device, 2 = unmapped
   function automatic int exp_tgt(input logic [31:0] a);
      if (a[31:24] == 8'h20) return 1;
      if (a < 32'h2000_0000) return 0;
      return 2;
   endfunction

   function automatic logic [31:0] exp_bus(input logic [31:0] a);
      return {8'h7E, a[23:0]};
   endfunction

   function automatic logic [31:0] resp_val(input logic [31:0] a);
      return a ^ 32'hC3A5_5A3C;
   endfunction

   task automatic txn(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                      input int lat_req, input int lat_rsp, input int lat_src);
      int          t;
      logic [31:0] ea;
      logic [31:0] val;
      t = exp_tgt(a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R5", "ready low after accept", 32'(req_ready), 32'h0);
      if (t == 2) begin
         check(!ram_req_valid && !dev_req_valid, "R4", "no port for unmapped",
               {30'h0, ram_req_valid, dev_req_valid}, 32'h0);
         check(rsp_valid && rsp_err, "R4", "error response",
               {30'h0, rsp_valid, rsp_err}, 32'h3);
         check(rsp_rdata == 32'h0, "R4", "error data", rsp_rdata, 32'h0);
      end else begin
         ea = (t == 0) ? a : exp_bus(a);
         for (int i = 0; i < lat_req; i++) begin
            @(negedge clk);
            check(t == 0 ? ram_req_valid : dev_req_valid, "R8", "valid held", 32'h0, 32'h1);
            check((t == 0 ? ram_addr : dev_addr) == ea, "R8", "addr held",
                  t == 0 ? ram_addr : dev_addr, ea);
         end
         if (t == 0) begin
            check(ram_req_valid && !dev_req_valid, "R1", "RAM port chosen",
                  {30'h0, ram_req_valid, dev_req_valid}, 32'h2);
            check(ram_addr == ea, "R1", "RAM addr", ram_addr, ea);
            check(ram_write == wr && ram_wdata == wd, "R1", "RAM write data", ram_wdata, wd);
            check(dev_uncached == 1'b0, "R3", "RAM not uncached", 32'(dev_uncached), 32'h0);
            ram_req_ready = 1'b1;
         end else begin
            check(dev_req_valid && !ram_req_valid, "R2", "device port chosen",
                  {30'h0, ram_req_valid, dev_req_valid}, 32'h1);
            check(dev_addr == ea, "R2", "bus addr", dev_addr, ea);
            check(dev_write == wr && dev_wdata == wd, "R2", "device write data", dev_wdata, wd);
            check(dev_uncached == 1'b1, "R3", "device uncached", 32'(dev_uncached), 32'h1);
            dev_req_ready = 1'b1;
         end
         @(negedge clk);
         ram_req_ready = 1'b0; dev_req_ready = 1'b0;
         check(!ram_req_valid && !dev_req_valid, "R8", "valid drops after handshake",
               {30'h0, ram_req_valid, dev_req_valid}, 32'h0);
         for (int i = 0; i < lat_rsp; i++) @(negedge clk);
         check(rsp_valid == 1'b0, "R6", "no early response", 32'(rsp_valid), 32'h0);
         check((t == 0) ? (ram_rsp_ready && !dev_rsp_ready) : (dev_rsp_ready && !ram_rsp_ready),
               "R6", "only selected rsp_ready", {30'h0, ram_rsp_ready, dev_rsp_ready},
               (t == 0) ? 32'h2 : 32'h1);
         val = resp_val(a);
         if (t == 0) begin ram_rsp_valid = 1'b1; ram_rsp_rdata = val; dev_rsp_rdata = ~val; end
         else        begin dev_rsp_valid = 1'b1; dev_rsp_rdata = val; ram_rsp_rdata = ~val; end
         @(negedge clk);
         ram_rsp_valid = 1'b0; dev_rsp_valid = 1'b0;
         ram_rsp_rdata = '0; dev_rsp_rdata = '0;
         check(rsp_valid && !rsp_err, "R6", "response ok", {30'h0, rsp_valid, rsp_err}, 32'h2);
         check(rsp_rdata == val, "R6", "response data", rsp_rdata, val);
      end
      for (int i = 0; i < lat_src; i++) begin
         @(negedge clk);
         check(rsp_valid == 1'b1, "R8", "response held", 32'(rsp_valid), 32'h1);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check(req_ready == 1'b1 && rsp_valid == 1'b0, "R5", "slot reopens",
            {30'h0, req_ready, rsp_valid}, 32'h2);
   endtask

   task automatic rev(input logic [31:0] b);
      logic [31:0] ep;
      bit          eh;
      eh = (b[31:24] == 8'h7E);
      ep = eh ? {8'h20, b[23:0]} : 32'h0;
      dma_bus_addr = b;
      #1;
      check(dma_hit == eh, "R7", "reverse hit", 32'(dma_hit), 32'(eh));
      check(dma_phys_addr == ep, "R7", "reverse addr", dma_phys_addr, ep);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(req_ready == 1'b1, "R9", "ready after reset", 32'(req_ready), 32'h1);
      check(!rsp_valid && !ram_req_valid && !dev_req_valid, "R9", "no valids after reset",
            {29'h0, rsp_valid, ram_req_valid, dev_req_valid}, 32'h0);
      // directed edges
      txn(32'h0000_0000, 1'b0, 32'h0, 0, 0, 0);
      txn(32'h1FFF_FFFF, 1'b1, 32'h1234_5678, 2, 1, 1);
      txn(32'h2000_0000, 1'b1, 32'hDEAD_BEEF, 1, 2, 0);
      txn(32'h20FF_FFFF, 1'b0, 32'h0, 3, 0, 2);
      txn(32'h2100_0000, 1'b0, 32'h0, 0, 0, 1);
      txn(32'hFFFF_FFFF, 1'b1, 32'h5555_AAAA, 0, 0, 0);
      txn(32'h7E00_0010, 1'b0, 32'h0, 0, 0, 0);
      rev(32'h7E00_0000);
      rev(32'h7EFF_FFFF);
      rev(32'h7F00_0000);
      rev(32'h2012_3456);
      rev(32'h7E21_5040);
      // random mix
      for (int n = 0; n < 80; n++) begin
         int          k;
         logic [31:0] a;
         k = $urandom % 3;
         case (k)
            0: a = $urandom % 32'h2000_0000;
            1: a = {8'h20, 24'($urandom)};
            default: a = 32'h2100_0000 + ($urandom % 32'hDF00_0000);
         endcase
         txn(a, 1'($urandom), $urandom, $urandom % 4, $urandom % 4, $urandom % 3);
         rev($urandom);
         rev({8'h7E, 24'($urandom)});
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule